// File: doc/BRIEF.md
# Shadow-Tag Delta-Miss Tracker

This block holds the tag directory of a four-way set-associative cache. The data array behind it can run either at full size or at half size. In half-size ("merged") operation only ways 0 and 1 have data behind them. The directory still keeps all four tags and a full four-deep recency order for every set. Because of this, the block can always tell which accesses would hit in the full-sized cache but miss in the half-sized one. It counts those accesses in a delta-miss counter. A power or voltage controller reads this counter to judge what the smaller cache costs.

Requests arrive on a valid/ready channel carrying a set index and a tag. The merged flag selects the operating mode for each access. Each accepted request produces a one-cycle response, one cycle later, with no back-pressure on the response side. The response holds a data-hit flag, the data way to use, and a fill request for the next level.

When a merged-mode access has to pull a block into the data ways, the block does two things. It moves the older data-way tag into a tag-only way through a single tag buffer. It writes the requested tag into the freed data way. The second tag write takes one extra cycle. During that cycle `req_ready` is low and the requester holds its request.

Top module: `shadow_tag_tracker`

## Requirements
- R1: After reset, `resp_valid` is 0, `req_ready` is 1, `delta_count` is 0, and every tag way of every set is invalid, so the first access to any set misses.
- R2: Each set keeps a recency order of its four ways, ranked 0 (most recent) to 3 (least recent). The accessed block becomes rank 0, and blocks ranked above it move down one rank. At reset way w holds rank w. In regular mode a miss replaces the way at rank 3.
- R3: In regular mode, `delta_count` goes up by one on a tag hit at rank 2 or 3. It stays the same on a hit at rank 0 or 1 and on a miss.
- R4: In regular mode, a hit answers with `resp_hit`=1, `fill_req`=0 and `resp_way` set to the way that hit. A miss answers with `resp_hit`=0, `fill_req`=1 and `resp_way` set to the replaced way.
- R5: In merged mode, `resp_way` is always 0 or 1. A tag hit in way 0 or 1 is a data hit with no fill.
- R6: In merged mode, a tag hit in way 2 or 3 answers as a miss with `fill_req`=1. The fill goes to the less recent of ways 0 and 1, and `delta_count` goes up when the hit rank is 2 or 3. The victim's tag moves into the way where the request was found, keeping its recency.
- R7: In merged mode, a full tag miss leaves `delta_count` unchanged. It fills the less recent data way, and the victim's tag moves into the rank-3 way, whose tag is dropped.
- R8: An access that relocates a tag drives `req_ready` low for exactly the next cycle. Regular-mode accesses never drop `req_ready`.
- R9: `clear` sets `delta_count` to 0 on the next edge, even when an access in the same cycle would have made it count up.
- R10: `resp_valid` is high for exactly the one cycle after each accepted request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high; low during a tag relocation |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Address tag |
| merged | input | 1 | 1 = half-size data array (ways 0 and 1 only) |
| clear | input | 1 | Zero the delta-miss counter |
| resp_valid | output | 1 | Response strobe, one cycle after acceptance |
| resp_hit | output | 1 | Data present in the data array |
| resp_way | output | 2 | Data way hit or to be filled |
| fill_req | output | 1 | Block must be fetched from the next level |
| delta_count | output | CNT_W | Count of full-size hits that miss at half size (saturating) |

## Verification
The assertions assume that the requester obeys the ready rule: a request offered while `req_ready` is low is neither accepted nor answered. They also assume that `clear` and `merged` are driven to known values every cycle. The bench keeps to these rules. It offers each request only after it sees `req_ready` high, and it drops `req_valid` once the response arrives. In merged mode, every sequence starts from a set whose two most recent blocks already sit in ways 0 and 1.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);
  typedef logic [WAY_W-1:0] way_t;
  typedef logic [WAY_W-1:0] age_t;
  localparam age_t AGE_MRU = age_t'(0);
  localparam age_t AGE_LRU = age_t'(WAYS - 1);
endpackage

// File: rtl/shadow_age_update.sv
module shadow_age_update
  import tracker_pkg::*;
(
  input  age_t ages_in  [WAYS],
  input  way_t tgt_way,
  input  age_t ref_age,
  output age_t ages_out [WAYS]
);
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (way_t'(w) == tgt_way)      ages_out[w] = AGE_MRU;
      else if (ages_in[w] < ref_age) ages_out[w] = age_t'(ages_in[w] + age_t'(1));
      else                           ages_out[w] = ages_in[w];
    end
  end
endmodule

// File: rtl/shadow_lookup.sv
module shadow_lookup
  import tracker_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W-1:0] set_tags [WAYS],
  input  logic [WAYS-1:0]  set_valid,
  input  age_t             set_ages [WAYS],
  input  logic [TAG_W-1:0] req_tag,
  input  logic             merged,
  output logic             tag_hit,
  output logic             data_hit,
  output logic             do_copy,
  output logic             delta_inc,
  output way_t             fill_way,
  output way_t             victim_way,
  output way_t             tgt_way,
  output age_t             next_ages [WAYS]
);
  logic [WAYS-1:0] hit_vec;
  way_t hit_way, lru_way;
  age_t ref_age;
  age_t upd [WAYS];

  always_comb begin
    hit_vec = '0;
    hit_way = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = set_valid[w] && (set_tags[w] == req_tag);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])               hit_way = way_t'(w);
      if (set_ages[w] == AGE_LRU)   lru_way = way_t'(w);
    end
    tag_hit    = |hit_vec;
    tgt_way    = tag_hit ? hit_way : lru_way;
    ref_age    = tag_hit ? set_ages[hit_way] : AGE_LRU;
    victim_way = (set_ages[0] > set_ages[1]) ? way_t'(0) : way_t'(1);
    // a target outside the data ways needs its tag swapped with the victim
    do_copy    = merged && tgt_way[WAY_W-1];
    data_hit   = tag_hit && !do_copy;
    fill_way   = do_copy ? victim_way : tgt_way;
    delta_inc  = tag_hit && ref_age[WAY_W-1];
  end

  shadow_age_update i_age (
    .ages_in  (set_ages),
    .tgt_way  (tgt_way),
    .ref_age  (ref_age),
    .ages_out (upd)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) next_ages[w] = upd[w];
    if (do_copy) begin
      next_ages[victim_way] = AGE_MRU;
      next_ages[tgt_way]    = upd[victim_way];
    end
  end
endmodule

// File: rtl/delta_counter.sv
module delta_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear)            count <= '0;
    else if (inc && (count != '1))  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/shadow_tag_tracker.sv
module shadow_tag_tracker
  import tracker_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_index,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             merged,
  input  logic             clear,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [1:0]       resp_way,
  output logic             fill_req,
  output logic [CNT_W-1:0] delta_count
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  age_t             age_q   [SETS][WAYS];

  logic             busy_q;
  logic [TAG_W-1:0] buf_tag_q;
  logic             buf_vld_q;
  logic [IDX_W-1:0] pend_set_q;
  way_t             pend_way_q;

  logic [TAG_W-1:0] set_tags [WAYS];
  age_t             set_ages [WAYS];
  logic [WAYS-1:0]  set_valid;
  logic tag_hit, data_hit, do_copy, delta_inc, accept;
  way_t fill_way, victim_way, tgt_way;
  age_t next_ages [WAYS];

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w] = tag_q[req_index][w];
      set_ages[w] = age_q[req_index][w];
    end
    set_valid = valid_q[req_index];
  end

  shadow_lookup #(.TAG_W(TAG_W)) i_lookup (
    .set_tags   (set_tags),
    .set_valid  (set_valid),
    .set_ages   (set_ages),
    .req_tag    (req_tag),
    .merged     (merged),
    .tag_hit    (tag_hit),
    .data_hit   (data_hit),
    .do_copy    (do_copy),
    .delta_inc  (delta_inc),
    .fill_way   (fill_way),
    .victim_way (victim_way),
    .tgt_way    (tgt_way),
    .next_ages  (next_ages)
  );

  // tag storage: the victim tag is captured in the buffer on the same edge
  // that the requested tag lands in the data way; the buffer drains next cycle
  always_ff @(posedge clk) begin
    if (accept && !data_hit) tag_q[req_index][fill_way] <= req_tag;
    if (busy_q)              tag_q[pend_set_q][pend_way_q] <= buf_tag_q;
    if (accept && do_copy)   buf_tag_q <= tag_q[req_index][victim_way];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= age_t'(w);
      end
      busy_q     <= 1'b0;
      buf_vld_q  <= 1'b0;
      pend_set_q <= '0;
      pend_way_q <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      fill_req   <= 1'b0;
    end else begin
      resp_valid <= accept;
      busy_q     <= accept && do_copy;
      if (accept) begin
        resp_hit <= data_hit;
        resp_way <= fill_way;
        fill_req <= !data_hit;
        for (int w = 0; w < WAYS; w++) age_q[req_index][w] <= next_ages[w];
        if (!data_hit) valid_q[req_index][fill_way] <= 1'b1;
        if (do_copy) begin
          buf_vld_q  <= valid_q[req_index][victim_way];
          pend_set_q <= req_index;
          pend_way_q <= tgt_way;
        end
      end
      if (busy_q) valid_q[pend_set_q][pend_way_q] <= buf_vld_q;
    end
  end

  delta_counter #(.CNT_W(CNT_W)) i_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .inc   (accept && delta_inc),
    .count (delta_count)
  );
endmodule

// File: rtl/shadow_tag_tracker_chk.sv
module shadow_tag_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             merged,
  input logic             clear,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [1:0]       resp_way,
  input logic             fill_req,
  input logic [CNT_W-1:0] delta_count
);
  a_r8_copy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  a_r8_no_copy_regular: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !merged) |=> req_ready);
  a_r10_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);
  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (delta_count == '0));
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (delta_count == $past(delta_count)) ||
               (delta_count == $past(delta_count) + CNT_W'(1)));
  a_r4_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit != fill_req));
  a_r5_merged_data_way: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && merged) |=> (resp_way[1] == 1'b0));
endmodule

bind shadow_tag_tracker shadow_tag_tracker_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .merged      (merged),
  .clear       (clear),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_way    (resp_way),
  .fill_req    (fill_req),
  .delta_count (delta_count)
);

// File: tb/test_shadow_tag_tracker.sv
module test_shadow_tag_tracker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SETS = 16, TAG_W = 8, CNT_W = 16, IDX_W = 4;

  typedef struct packed {
    logic       m;
    logic [3:0] set;
    logic [7:0] tag;
    logic       hit;
    logic [1:0] way;
    logic       fill;
    logic [15:0] delta;
    logic       busy;
  } vec_t;

  // R2/R3/R4 regular warm-up and hits; R5/R6/R7/R8 merged relocations
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1, 8'h11, 1'b0, 2'd3, 1'b1, 16'd0, 1'b0},
    '{1'b0, 4'd1, 8'h22, 1'b0, 2'd2, 1'b1, 16'd0, 1'b0},
    '{1'b0, 4'd1, 8'h33, 1'b0, 2'd1, 1'b1, 16'd0, 1'b0},
    '{1'b0, 4'd1, 8'h44, 1'b0, 2'd0, 1'b1, 16'd0, 1'b0},
    '{1'b0, 4'd1, 8'h11, 1'b1, 2'd3, 1'b0, 16'd1, 1'b0},
    '{1'b0, 4'd1, 8'h44, 1'b1, 2'd0, 1'b0, 16'd1, 1'b0},
    '{1'b0, 4'd1, 8'h33, 1'b1, 2'd1, 1'b0, 16'd2, 1'b0},
    '{1'b1, 4'd1, 8'h44, 1'b1, 2'd0, 1'b0, 16'd2, 1'b0},
    '{1'b1, 4'd1, 8'h11, 1'b0, 2'd1, 1'b1, 16'd3, 1'b1},
    '{1'b1, 4'd1, 8'h33, 1'b0, 2'd0, 1'b1, 16'd4, 1'b1},
    '{1'b1, 4'd1, 8'h55, 1'b0, 2'd1, 1'b1, 16'd4, 1'b1},
    '{1'b1, 4'd1, 8'h22, 1'b0, 2'd0, 1'b1, 16'd4, 1'b1},
    '{1'b1, 4'd1, 8'h11, 1'b0, 2'd1, 1'b1, 16'd5, 1'b1},
    '{1'b1, 4'd1, 8'h55, 1'b0, 2'd0, 1'b1, 16'd6, 1'b1},
    '{1'b1, 4'd2, 8'h77, 1'b0, 2'd1, 1'b1, 16'd6, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, merged = 1'b0, clear = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, resp_valid, resp_hit, fill_req;
  logic [1:0] resp_way;
  logic [CNT_W-1:0] delta_count;
  int n_chk = 0, n_bad = 0;
  logic busy_seen;

  always #2 clk = ~clk;

  shadow_tag_tracker #(.SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_shadow_tag_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_tag(req_tag), .merged(merged), .clear(clear),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .fill_req(fill_req), .delta_count(delta_count)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic access(input logic m, input logic [3:0] s, input logic [7:0] t, input logic clr);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; merged = m; req_index = s; req_tag = t; clear = clr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; clear = 1'b0;
    busy_seen = !req_ready;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "resp_valid", int'(resp_valid), 0);
    check("R1", "req_ready", int'(req_ready), 1);
    check("R1", "delta_count", int'(delta_count), 0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].m, VECS[i].set, VECS[i].tag, 1'b0);
      check("R10", $sformatf("v%0d resp_valid", i), int'(resp_valid), 1);
      check(VECS[i].m ? "R6" : "R4", $sformatf("v%0d hit", i), int'(resp_hit), int'(VECS[i].hit));
      check(VECS[i].m ? "R5" : "R2", $sformatf("v%0d way", i), int'(resp_way), int'(VECS[i].way));
      check(VECS[i].m ? "R7" : "R4", $sformatf("v%0d fill", i), int'(fill_req), int'(VECS[i].fill));
      check(VECS[i].m ? "R6" : "R3", $sformatf("v%0d delta", i), int'(delta_count), int'(VECS[i].delta));
      check("R8", $sformatf("v%0d busy", i), int'(busy_seen), int'(VECS[i].busy));
      @(negedge clk);
      check("R10", $sformatf("v%0d resp drop", i), int'(resp_valid), 0);
      check("R8", $sformatf("v%0d ready back", i), int'(req_ready), 1);
    end

    // R9: clear alone
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R9", "clear alone", int'(delta_count), 0);

    // R9: clear beats a same-cycle increment (set 1 tag 0x33 sits at rank 3)
    access(1'b1, 4'd1, 8'h33, 1'b1);
    check("R9", "clear wins", int'(delta_count), 0);
    check("R6", "shadow hit way", int'(resp_way), 1);

    // R6: counting resumes; 0x22 at rank 3 in a tag-only way
    access(1'b1, 4'd1, 8'h22, 1'b0);
    check("R6", "count resumes", int'(delta_count), 1);
    check("R6", "fill way", int'(resp_way), 0);
    check("R8", "copy busy", int'(busy_seen), 1);

    // R1: untouched set misses in regular mode, fills rank-3 way
    access(1'b0, 4'd9, 8'h11, 1'b0);
    check("R1", "fresh set miss", int'(resp_hit), 0);
    check("R2", "fresh set way", int'(resp_way), 3);

    summary();
    $finish;
  end
endmodule